// File: doc/BRIEF.md
# Clock-Gate and Reset-Release Control Bank

This block is a small register bank on a 32-bit APB slave port. It holds two 7-bit control vectors for a USB subsystem. The first vector drives seven clock-gate enables. The second drives seven reset releases, where a 1 lets the corresponding block out of reset. The bank drives both vectors straight onto its output pins.

Each vector is reached through three word addresses. A plain register reads the vector back and loads it when written. A set alias ORs the written ones into the vector. A clear alias removes the written ones from it. This lets separate software agents change individual gates or resets without a read-modify-write race.

Per-bit roles, identical for both vectors: bit 0 system, bit 1 reference, bit 2 alternate reference, bit 3 suspend, bit 4 core, bit 5 low-jitter, bit 6 PHY test.

The APB transfer is the only handshake. A transfer's setup phase is `psel`=1 with `penable`=0. Its access phase is `psel`=1 with `penable`=1. The slave never stalls: `pready` is 1, so every access phase completes in one cycle.

Top module: `usb_clkrst_bank`

## Requirements
- R1: After reset, both vectors are zero, so `clk_en_o` and `rst_rel_o` are 0 (all clocks gated, all blocks held in reset).
- R2: A write to the plain register (offset 0x00 for clocks, 0x10 for resets) loads pwdata[6:0] into that vector at the clock edge that ends the access phase.
- R3: A write to a set alias (0x04 clocks, 0x14 resets) sets every vector bit whose pwdata bit is 1. Bits written as 0 are unchanged.
- R4: A write to a clear alias (0x08 clocks, 0x18 resets) clears every vector bit whose pwdata bit is 1. Bits written as 0 are unchanged.
- R5: pwdata bits 31:7 have no effect on any vector. Reads return 0 in bits 31:7.
- R6: A read of any of a vector's three addresses returns that vector in prdata[6:0] during the access phase.
- R7: An access to any other offset, including one that is not a multiple of 4, returns prdata=0 with pslverr=1 in its access phase. Such a write changes neither vector.
- R8: `pready` is 1 in every access phase, so every transfer takes exactly a setup cycle plus one access cycle. Mapped accesses give pslverr=0.
- R9: A write to one vector's addresses leaves the other vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response for unmapped offsets |
| clk_en_o | output | 7 | Clock-gate enables, bit roles as listed above |
| rst_rel_o | output | 7 | Reset releases, 1 = out of reset |

## Verification
On every cycle, the assertions check three things. A set write never lowers a bit. A clear write never raises one. A plain write lands exactly the written low bits. They also check that a vector with no write strobe holds its value, and that an errored access returns zero and changes nothing.

Only the bench scenarios show the rest. These are the address map itself and that each alias reads back the live vector. They also cover that wide write data is truncated and that the two vectors stay independent. All are compared against a reference model in a scoreboard.

// File: rtl/usb_cr_pkg.sv
package usb_cr_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } vec_op_e;

  localparam int BIT_SYS     = 0;
  localparam int BIT_REF     = 1;
  localparam int BIT_ALT_REF = 2;
  localparam int BIT_SUSPEND = 3;
  localparam int BIT_CORE    = 4;
  localparam int BIT_LOW_JIT = 5;
  localparam int BIT_PHY_TST = 6;
endpackage

// File: rtl/cr_addr_decode.sv
module cr_addr_decode
  import usb_cr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_VEC = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_VEC-1:0] sel,
  output logic               hit,
  output vec_op_e            op
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       sub;
  logic             aligned;

  assign blk     = addr[ADDR_W-1:4];
  assign sub     = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    case (sub)
      2'd0:    op = OP_LOAD;
      2'd1:    op = OP_SET;
      2'd2:    op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_sel
    assign sel[k] = aligned && (sub != 2'd3) && (blk == BLK_W'(k));
  end

  assign hit = |sel;
endmodule

// File: rtl/cr_vec_reg.sv
module cr_vec_reg
  import usb_cr_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vec_op_e          op,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else begin
      case (op)
        OP_LOAD: vec_q <= wdata;
        OP_SET:  vec_q <= vec_q | wdata;
        OP_CLR:  vec_q <= vec_q & ~wdata;
        default: vec_q <= vec_q;
      endcase
    end
  end

  assign vec_o = vec_q;

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> vec_o == $past(wdata)); // R2
  AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SET |=> ((vec_o & $past(vec_o)) == $past(vec_o))); // R3
  AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLR |=> ((vec_o | $past(vec_o)) == $past(vec_o))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_NONE |=> $stable(vec_o)); // R9
endmodule

// File: rtl/usb_clkrst_bank.sv
module usb_clkrst_bank
  import usb_cr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 7
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [VEC_W-1:0]  clk_en_o,
  output logic [VEC_W-1:0]  rst_rel_o
);
  localparam int NUM_VEC = 2;
  localparam int IDX_CLK = 0;
  localparam int IDX_RST = 1;

  logic [NUM_VEC-1:0] sel;
  logic               hit;
  vec_op_e            dec_op;
  logic               access;
  logic               wr_strobe;
  logic [VEC_W-1:0]   vec [NUM_VEC];

  assign access    = psel && penable;
  assign wr_strobe = access && pwrite && hit;

  cr_addr_decode #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_dec (
    .addr (paddr),
    .sel  (sel),
    .hit  (hit),
    .op   (dec_op)
  );

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
    vec_op_e op_k;
    assign op_k = (wr_strobe && sel[k]) ? dec_op : OP_NONE;
    cr_vec_reg #(.VEC_W(VEC_W)) u_reg (
      .clk   (pclk),
      .rst_n (presetn),
      .op    (op_k),
      .wdata (pwdata[VEC_W-1:0]),
      .vec_o (vec[k])
    );
  end

  always_comb begin
    prdata = '0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (sel[k]) prdata[VEC_W-1:0] = vec[k];
    end
  end

  assign pready    = 1'b1;
  assign pslverr   = access && !hit;
  assign clk_en_o  = vec[IDX_CLK];
  assign rst_rel_o = vec[IDX_RST];

  AST_ERR_DATA_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> prdata == '0); // R7
  AST_ERR_WRITE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && pwrite) |=> ($stable(clk_en_o) && $stable(rst_rel_o))); // R7
  AST_READ_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (access && !pwrite) |=> ($stable(clk_en_o) && $stable(rst_rel_o))); // R6
endmodule

// File: tb/test_usb_clkrst_bank.sv
module test_usb_clkrst_bank;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic [6:0]  clk_en_o;
  logic [6:0]  rst_rel_o;

  int errors = 0;
  int checks = 0;
  logic [6:0] m_clk = '0;
  logic [6:0] m_rst = '0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  logic        q_chkd[$];
  string       q_tag[$];

  always #10 pclk = ~pclk;

  usb_clkrst_bank i_usb_clkrst_bank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .clk_en_o(clk_en_o),
    .rst_rel_o(rst_rel_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 ||
           a == 8'h10 || a == 8'h14 || a == 8'h18;
  endfunction

  function automatic logic [6:0] model_vec(logic [7:0] a);
    return (a[4] == 1'b0) ? m_clk : m_rst;
  endfunction

  task automatic apb(string tag, logic [7:0] a, logic wr, logic [31:0] d);
    @(posedge pclk); #2;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    q_tag.push_back(tag);
    q_err.push_back(!mapped(a));
    q_chkd.push_back(!wr);
    q_data.push_back(mapped(a) ? {25'd0, model_vec(a)} : 32'd0);
    @(posedge pclk); #2;
    penable = 1'b1;
    @(posedge pclk); #2;
    psel = 1'b0; penable = 1'b0;
    if (wr && mapped(a)) begin
      logic [6:0] w;
      logic [6:0] nv;
      w = d[6:0];
      case (a[3:2])
        2'd0: nv = w;
        2'd1: nv = model_vec(a) | w;
        default: nv = model_vec(a) & ~w;
      endcase
      if (a[4] == 1'b0) m_clk = nv; else m_rst = nv;
    end
  endtask

  task automatic check_outs(string tag);
    @(negedge pclk);
    check({tag, " clk_en_o"}, {25'd0, clk_en_o}, {25'd0, m_clk});
    check({tag, " rst_rel_o"}, {25'd0, rst_rel_o}, {25'd0, m_rst});
  endtask

  // Monitor: pops scoreboard entries at each access phase.
  always @(negedge pclk) begin
    if (psel && penable && q_tag.size() > 0) begin
      string t;
      logic e;
      logic c;
      logic [31:0] dd;
      t = q_tag.pop_front();
      e = q_err.pop_front();
      c = q_chkd.pop_front();
      dd = q_data.pop_front();
      check({t, " R8 pready"}, {31'd0, pready}, 32'd1);
      check({t, " pslverr"}, {31'd0, pslverr}, {31'd0, e});
      if (c) check({t, " prdata"}, prdata, dd);
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge pclk);
    check_outs("R1 reset");
    #3 presetn = 1'b1;
    check_outs("R1 after release");
    apb("R1 read clk", 8'h00, 1'b0, 32'h0);
    apb("R1 read rst", 8'h10, 1'b0, 32'h0);

    apb("R2 R5 load clk", 8'h00, 1'b1, 32'hFFFF_FF85);
    check_outs("R2 R5 load clk");
    apb("R5 R6 read clk", 8'h00, 1'b0, 32'h0);

    apb("R3 set clk", 8'h04, 1'b1, 32'h0000_0042);
    check_outs("R3 set clk");
    apb("R6 read set alias", 8'h04, 1'b0, 32'h0);
    apb("R6 read clr alias", 8'h08, 1'b0, 32'h0);

    apb("R4 clr clk", 8'h08, 1'b1, 32'hFFFF_FF03);
    check_outs("R4 clr clk");

    apb("R3 R9 set rst", 8'h14, 1'b1, 32'h0000_007F);
    check_outs("R3 R9 set rst");
    apb("R4 R9 clr rst", 8'h18, 1'b1, 32'h0000_0010);
    check_outs("R4 R9 clr rst");
    apb("R6 read rst", 8'h10, 1'b0, 32'h0);

    apb("R3 set zero", 8'h04, 1'b1, 32'hFFFF_FF80);
    check_outs("R3 set zero");
    apb("R4 clr zero", 8'h18, 1'b1, 32'h0000_0000);
    check_outs("R4 clr zero");

    apb("R7 wr 0x0C", 8'h0C, 1'b1, 32'h0000_007F);
    check_outs("R7 wr 0x0C");
    apb("R7 wr 0x02", 8'h02, 1'b1, 32'h0000_0000);
    check_outs("R7 wr 0x02");
    apb("R7 rd 0x20", 8'h20, 1'b0, 32'h0);
    apb("R7 rd 0x1C", 8'h1C, 1'b0, 32'h0);
    apb("R7 rd 0x11", 8'h11, 1'b0, 32'h0);

    apb("R2 load rst", 8'h10, 1'b1, 32'h0000_0000);
    check_outs("R2 R9 load rst");
    apb("R2 load clk", 8'h00, 1'b1, 32'h0000_007F);
    check_outs("R2 load clk");
    apb("R6 final clk", 8'h08, 1'b0, 32'h0);

    repeat (3) @(posedge pclk);
    check("R8 scoreboard drained", q_tag.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule